// File: doc/BRIEF.md
# NAND Flash Command Cycle Sequencer

This block places single command, address or write-data bytes on an 8-bit NAND flash bus. For a command byte it raises the command latch enable. For an address byte it raises the address latch enable. It pulses an active-low write strobe while the byte sits on the data lines. All three byte kinds share one timing engine. A programmable setup interval comes before the strobe. Wait states lengthen the strobe, and a relaxed-timing flag doubles them. A programmable hold interval follows the strobe.

A request can ask the block to wait for the device afterwards. This suits long operations such as a page read, during which the device pulls its ready/busy line low. For such a request the block first sits through a fixed guard interval and ignores ready/busy. This keeps it from seeing "ready" before the device has had time to pull the line low. After the guard, the block stalls until ready/busy reads high on consecutive clocks. A one-clock done pulse marks the end of every request.

Top module: `nand_cmd_seq`

## Requirements
- R1: While reset is asserted, and at once when it is asserted in the middle of a bus cycle, `nf_we_n` is 1 and `nf_cle`, `nf_ale`, `nf_dq` and `done` are 0.
- R2: Request kind encoding: 2'b00 is a command (`nf_cle` high), 2'b01 is an address (`nf_ale` high), 2'b10 and 2'b11 are write data (neither high). The selected marker stays high on every cycle from the first setup cycle through the last hold cycle. `nf_cle` and `nf_ale` are never high together.
- R3: `nf_dq` carries the request byte from the first setup cycle through the last hold cycle and is 0 on all other cycles.
- R4: The bus cycle starts on the clock after the request is accepted. `nf_we_n` stays high for the first `cfg_setup` cycles of it.
- R5: After setup, `nf_we_n` is low for 1 + `cfg_wait` cycles, or for 1 + 2×`cfg_wait` cycles when `cfg_relax` is 1.
- R6: After `nf_we_n` rises, the hold phase lasts 1 + `cfg_hold` cycles. For a request without a ready wait, `done` follows on the next cycle. With all timing inputs at 0, the bus cycle lasts two clocks and `done` comes on the third.
- R7: `done` is high for exactly one clock per request. A request is accepted only on a cycle when the block is idle, which is never the cycle in which `done` is high.
- R8: A request presented while a bus cycle, a ready wait or the done cycle is in progress is dropped. No further bus cycle or done pulse comes from it.
- R9: The request kind, the byte, the ready-wait flag and all timing inputs are captured when the request is accepted. Changing them afterwards does not affect the cycle in progress.
- R10: For a request with `req_wait_rb` set, GUARD_CYC clock cycles (default 4) follow the hold phase. During these cycles `rb_in` is ignored.
- R11: After the guard, `done` rises on the cycle after the one in which `rb_in` is sampled high for the second consecutive clock. A single-clock high on `rb_in` does not end the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe; taken only while the block is idle |
| req_kind | input | 2 | 00 command, 01 address, 10/11 write data |
| req_byte | input | 8 | Byte to place on the bus |
| req_wait_rb | input | 1 | Wait for the device to become ready after this byte |
| cfg_setup | input | 2 | Setup cycles before the strobe |
| cfg_wait | input | 4 | Wait states added to the strobe |
| cfg_relax | input | 1 | Doubles the wait states |
| cfg_hold | input | 2 | Extra hold cycles after the strobe |
| rb_in | input | 1 | Device ready/busy line, high means ready |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Active-low write strobe |
| nf_dq | output | 8 | Flash data bus |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench attacks the guard window in two ways. It drives ready/busy high through the whole guard. It also raises ready/busy a cycle before the guard ends. A design that sampled the line too early would finish one or more cycles sooner than expected. A lone one-clock high on ready/busy during the wait shows whether the block accepts a glitch as ready. The bench also scrambles every request and timing input right after acceptance, and retries a request in mid-cycle. Both catch a sequencer that reads live inputs or starts a second cycle. The zero-parameter case and the fifteen-wait-state relaxed case bound the strobe counter, where an off-by-one would show up as a wrong strobe width.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'b00,
    KIND_ADDR = 2'b01,
    KIND_DATA = 2'b10,
    KIND_DALT = 2'b11
  } nseq_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_GUARD,
    PH_RBWAIT,
    PH_DONE
  } nseq_phase_e;

endpackage

// File: rtl/nseq_rst_sync.sv
module nseq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q   <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_n_out <= stage_q;
    end
  end

endmodule

// File: rtl/nseq_len_calc.sv
// Turns the captured timing settings into down-counter reload values
// (phase length minus one) for each phase of a bus cycle.
module nseq_len_calc #(
  parameter int SETUP_W   = 2,
  parameter int WAIT_W    = 4,
  parameter int HOLD_W    = 2,
  parameter int GUARD_CYC = 4,
  parameter int CNT_W     = 5,
  parameter bit RELAX_EN  = 1'b1
) (
  input  logic [SETUP_W-1:0] setup,
  input  logic [WAIT_W-1:0]  waits,
  input  logic [HOLD_W-1:0]  hold,
  input  logic               relax,
  output logic               setup_none,
  output logic [CNT_W-1:0]   setup_ld,
  output logic [CNT_W-1:0]   strobe_ld,
  output logic [CNT_W-1:0]   hold_ld,
  output logic [CNT_W-1:0]   guard_ld
);

  always_comb begin
    setup_none = (setup == '0);
    setup_ld   = CNT_W'(setup) - CNT_W'(1);
    hold_ld    = CNT_W'(hold);
    guard_ld   = CNT_W'(GUARD_CYC - 1);
  end

  generate
    if (RELAX_EN) begin : g_relax
      always_comb begin
        if (relax) strobe_ld = CNT_W'({waits, 1'b0});
        else       strobe_ld = CNT_W'(waits);
      end
    end else begin : g_plain
      logic unused_relax;
      assign unused_relax = relax;
      always_comb strobe_ld = CNT_W'(waits);
    end
  endgenerate

endmodule

// File: rtl/nseq_rb_filter.sv
// Reports ready once rb_in has been high on RB_STABLE consecutive clocks
// while enabled; the history is cleared whenever it is not enabled.
module nseq_rb_filter #(
  parameter int RB_STABLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rb_in,
  output logic rb_ok
);

  localparam int HW = $clog2(RB_STABLE) + 1;

  logic [HW-1:0] hi_q, hi_d;
  logic          at_last;

  assign at_last = (hi_q == HW'(RB_STABLE - 1));
  assign rb_ok   = en && rb_in && at_last;

  always_comb begin
    if (!en || !rb_in) hi_d = '0;
    else if (at_last)  hi_d = hi_q;
    else               hi_d = hi_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

endmodule

// File: rtl/nseq_phase_ctl.sv
module nseq_phase_ctl
  import nseq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             setup_none,
  input  logic             need_rb,
  input  logic [CNT_W-1:0] setup_ld,
  input  logic [CNT_W-1:0] strobe_ld,
  input  logic [CNT_W-1:0] hold_ld,
  input  logic [CNT_W-1:0] guard_ld,
  input  logic             rb_ok,
  output nseq_phase_e      phase
);

  nseq_phase_e      ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign phase    = ph_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_zero ? cnt_q : cnt_q - CNT_W'(1);
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          if (setup_none) begin
            ph_d  = PH_STROBE;
            cnt_d = strobe_ld;
          end else begin
            ph_d  = PH_SETUP;
            cnt_d = setup_ld;
          end
        end
      end
      PH_SETUP: if (cnt_zero) begin
        ph_d  = PH_STROBE;
        cnt_d = strobe_ld;
      end
      PH_STROBE: if (cnt_zero) begin
        ph_d  = PH_HOLD;
        cnt_d = hold_ld;
      end
      PH_HOLD: if (cnt_zero) begin
        if (need_rb) begin
          ph_d  = PH_GUARD;
          cnt_d = guard_ld;
        end else begin
          ph_d  = PH_DONE;
        end
      end
      PH_GUARD:  if (cnt_zero) ph_d = PH_RBWAIT;
      PH_RBWAIT: if (rb_ok)    ph_d = PH_DONE;
      PH_DONE:                 ph_d = PH_IDLE;
      default:                 ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nseq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_W   = 2,
  parameter int WAIT_W    = 4,
  parameter int HOLD_W    = 2,
  parameter int GUARD_CYC = 4,
  parameter int RB_STABLE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [DATA_W-1:0]  req_byte,
  input  logic               req_wait_rb,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               cfg_relax,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic               rb_in,
  output logic               nf_cle,
  output logic               nf_ale,
  output logic               nf_we_n,
  output logic [DATA_W-1:0]  nf_dq,
  output logic               done
);

  localparam int STROBE_BITS = WAIT_W + 1;
  localparam int GUARD_BITS  = $clog2(GUARD_CYC + 1);
  localparam int CNT_A       = (STROBE_BITS > GUARD_BITS) ? STROBE_BITS : GUARD_BITS;
  localparam int CNT_B       = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
  localparam int CNT_W       = (CNT_A > CNT_B) ? CNT_A : CNT_B;

  logic        rst_n_s;
  nseq_phase_e phase;
  logic        accept;
  logic        bus_active;

  nseq_kind_e         kind_q;
  logic [DATA_W-1:0]  byte_q;
  logic               rb_q;
  logic [SETUP_W-1:0] setup_q;
  logic [WAIT_W-1:0]  wait_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               relax_q;

  logic [SETUP_W-1:0] setup_sel;
  logic [WAIT_W-1:0]  wait_sel;
  logic [HOLD_W-1:0]  hold_sel;
  logic               relax_sel;
  logic               rb_sel;

  logic             setup_none;
  logic [CNT_W-1:0] setup_ld, strobe_ld, hold_ld, guard_ld;
  logic             rb_ok;

  nseq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign accept = req_valid && (phase == PH_IDLE);

  // Captured request and timing, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      kind_q  <= KIND_DATA;
      byte_q  <= '0;
      rb_q    <= 1'b0;
      setup_q <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
      relax_q <= 1'b0;
    end else if (accept) begin
      kind_q  <= nseq_kind_e'(req_kind);
      byte_q  <= req_byte;
      rb_q    <= req_wait_rb;
      setup_q <= cfg_setup;
      wait_q  <= cfg_wait;
      hold_q  <= cfg_hold;
      relax_q <= cfg_relax;
    end
  end

  // The first reload happens on the accept edge, before capture settles.
  always_comb begin
    if (accept) begin
      setup_sel = cfg_setup;
      wait_sel  = cfg_wait;
      hold_sel  = cfg_hold;
      relax_sel = cfg_relax;
      rb_sel    = req_wait_rb;
    end else begin
      setup_sel = setup_q;
      wait_sel  = wait_q;
      hold_sel  = hold_q;
      relax_sel = relax_q;
      rb_sel    = rb_q;
    end
  end

  nseq_len_calc #(
    .SETUP_W   (SETUP_W),
    .WAIT_W    (WAIT_W),
    .HOLD_W    (HOLD_W),
    .GUARD_CYC (GUARD_CYC),
    .CNT_W     (CNT_W),
    .RELAX_EN  (1'b1)
  ) u_len (
    .setup      (setup_sel),
    .waits      (wait_sel),
    .hold       (hold_sel),
    .relax      (relax_sel),
    .setup_none (setup_none),
    .setup_ld   (setup_ld),
    .strobe_ld  (strobe_ld),
    .hold_ld    (hold_ld),
    .guard_ld   (guard_ld)
  );

  nseq_rb_filter #(.RB_STABLE(RB_STABLE)) u_rbf (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (phase == PH_RBWAIT),
    .rb_in (rb_in),
    .rb_ok (rb_ok)
  );

  nseq_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (accept),
    .setup_none (setup_none),
    .need_rb    (rb_sel),
    .setup_ld   (setup_ld),
    .strobe_ld  (strobe_ld),
    .hold_ld    (hold_ld),
    .guard_ld   (guard_ld),
    .rb_ok      (rb_ok),
    .phase      (phase)
  );

  assign bus_active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  always_comb begin
    nf_cle  = bus_active && (kind_q == KIND_CMD);
    nf_ale  = bus_active && (kind_q == KIND_ADDR);
    nf_we_n = (phase != PH_STROBE);
    nf_dq   = bus_active ? byte_q : '0;
    done    = (phase == PH_DONE);
  end

endmodule

// File: rtl/nseq_checks.sv
module nseq_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we_n,
  input logic              cle,
  input logic              ale,
  input logic [DATA_W-1:0] dq,
  input logic              done,
  input logic              rb_in,
  input logic              rb_q
);

  AST_MARKERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R2

  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(cle) && $stable(ale) && $stable(dq))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (we_n && !cle && !ale && (dq == '0))); // R6

  AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rb_q) |-> $past(we_n)); // R6

  AST_READY_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rb_q) |-> ($past(rb_in) && $past(rb_in, 2))); // R11

endmodule

bind nand_cmd_seq nseq_checks #(.DATA_W(DATA_W)) u_checks (
  .clk   (clk),
  .rst_n (rst_n),
  .we_n  (nf_we_n),
  .cle   (nf_cle),
  .ale   (nf_ale),
  .dq    (nf_dq),
  .done  (done),
  .rb_in (rb_in),
  .rb_q  (rb_q)
);

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;

  localparam int GUARD = 4;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] data;
    logic [1:0] s;
    logic [3:0] w;
    logic [1:0] h;
    logic       relax;
    logic       rb;
    logic [7:0] rb_low;
    logic [7:0] pulse;
  } vec_t;

  // kind, byte, setup, wait, hold, relax, wait_rb, rb low until, single high pulse at
  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'h90, 2'd0, 4'd0,  2'd0, 1'b0, 1'b0, 8'd5,  8'd0},
    '{2'd1, 8'hA5, 2'd1, 4'd0,  2'd1, 1'b0, 1'b0, 8'd0,  8'd0},
    '{2'd2, 8'h3C, 2'd0, 4'd2,  2'd0, 1'b1, 1'b0, 8'd0,  8'd0},
    '{2'd3, 8'hC3, 2'd2, 4'd1,  2'd2, 1'b0, 1'b0, 8'd3,  8'd0},
    '{2'd0, 8'hFF, 2'd3, 4'd15, 2'd3, 1'b1, 1'b0, 8'd0,  8'd0},
    '{2'd0, 8'h30, 2'd0, 4'd0,  2'd0, 1'b0, 1'b1, 8'd0,  8'd0},
    '{2'd0, 8'h35, 2'd1, 4'd1,  2'd0, 1'b0, 1'b1, 8'd20, 8'd0},
    '{2'd1, 8'h5A, 2'd0, 4'd0,  2'd0, 1'b0, 1'b1, 8'd30, 8'd9},
    '{2'd2, 8'h01, 2'd0, 4'd0,  2'd0, 1'b0, 1'b1, 8'd5,  8'd0}
  };

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_kind;
  logic [7:0] req_byte;
  logic       req_wait_rb;
  logic [1:0] cfg_setup;
  logic [3:0] cfg_wait;
  logic       cfg_relax;
  logic [1:0] cfg_hold;
  logic       rb_in;
  logic       nf_cle, nf_ale, nf_we_n, done;
  logic [7:0] nf_dq;

  int total;
  int bad;
  bit finished;

  nand_cmd_seq #(.GUARD_CYC(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_byte(req_byte), .req_wait_rb(req_wait_rb), .cfg_setup(cfg_setup),
    .cfg_wait(cfg_wait), .cfg_relax(cfg_relax), .cfg_hold(cfg_hold),
    .rb_in(rb_in), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_dq(nf_dq), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " we_n"}, int'(nf_we_n), 1);
    chk({tag, " cle"},  int'(nf_cle), 0);
    chk({tag, " ale"},  int'(nf_ale), 0);
    chk({tag, " dq"},   int'(nf_dq), 0);
    chk({tag, " done"}, int'(done), 0);
  endtask

  function automatic bit rbv(input vec_t v, input int c);
    return (c > int'(v.rb_low)) || (v.pulse != 0 && c == int'(v.pulse));
  endfunction

  // Cycle c = 1 is the first clock after the accepting edge.
  task automatic run_vec(input vec_t v, input int idx);
    int wp, t_last, p, done_at;
    string dtag;
    wp      = v.relax ? 2 * int'(v.w) : int'(v.w);
    t_last  = int'(v.s) + wp + int'(v.h) + 2;
    p       = t_last + 1 + GUARD;
    done_at = t_last + 1;
    if (v.rb) begin
      done_at = 0;
      for (int c = p + 1; c < 1000 && done_at == 0; c++)
        if (rbv(v, c) && rbv(v, c - 1)) done_at = c + 1;
    end
    @(negedge clk);
    req_valid   = 1'b1;
    req_kind    = v.kind;
    req_byte    = v.data;
    req_wait_rb = v.rb;
    cfg_setup   = v.s;
    cfg_wait    = v.w;
    cfg_relax   = v.relax;
    cfg_hold    = v.h;
    rb_in       = rbv(v, 0);
    for (int c = 1; c <= done_at + 3; c++) begin
      @(negedge clk);
      if (c > done_at) begin
        chk_idle($sformatf("R8 vec%0d c%0d quiet", idx, c));
      end else begin
        chk($sformatf("R2 vec%0d c%0d cle", idx, c), int'(nf_cle),
            int'(c <= t_last && v.kind == 2'd0));
        chk($sformatf("R2 vec%0d c%0d ale", idx, c), int'(nf_ale),
            int'(c <= t_last && v.kind == 2'd1));
        chk($sformatf("R3 vec%0d c%0d dq", idx, c), int'(nf_dq),
            (c <= t_last) ? int'(v.data) : 0);
        chk($sformatf("%s R9 vec%0d c%0d we_n", (c <= int'(v.s)) ? "R4" : "R5", idx, c),
            int'(nf_we_n), int'(!(c >= int'(v.s) + 1 && c <= int'(v.s) + 1 + wp)));
        if (!v.rb)   dtag = "R6 R7";
        else if (c < p) dtag = "R10";
        else         dtag = "R11";
        chk($sformatf("%s vec%0d c%0d done", dtag, idx, c), int'(done), int'(c == done_at));
      end
      rb_in = rbv(v, c);
      if (c == 1) begin
        // R9: scramble everything after acceptance
        req_valid   = 1'b0;
        req_kind    = v.kind ^ 2'd1;
        req_byte    = ~v.data;
        req_wait_rb = ~v.rb;
        cfg_setup   = ~v.s;
        cfg_wait    = ~v.w;
        cfg_relax   = ~v.relax;
        cfg_hold    = ~v.h;
      end else if (c == 2) begin
        req_valid = 1'b1;   // R8: request while busy must be dropped
      end else if (c == 3) begin
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0;
    bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_kind = 2'd0;
    req_byte = 8'h00;
    req_wait_rb = 1'b0;
    cfg_setup = '0;
    cfg_wait = '0;
    cfg_relax = 1'b0;
    cfg_hold = '0;
    rb_in = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 after release");

    // Table walk
    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R1: reset in the middle of a long strobe
    @(negedge clk);
    req_valid = 1'b1;
    req_kind = 2'd0;
    req_byte = 8'h77;
    req_wait_rb = 1'b0;
    cfg_setup = 2'd0;
    cfg_wait = 4'd15;
    cfg_relax = 1'b1;
    cfg_hold = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 strobe active before reset", int'(nf_we_n), 0);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 mid-cycle reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 after mid-cycle reset");

    // Recovery: a normal cycle after the aborted one
    run_vec(TBL[1], 100);
    // Back-to-back requests with no gap beyond idle
    run_vec(TBL[0], 101);
    run_vec(TBL[5], 102);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule